// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits (default 8) over several clock cycles and returns the full `2W`-bit product. It keeps three working registers: a multiplicand register, a multiplier register and an accumulator. The adder carry is a one-bit value that feeds the top of the accumulator. The product is built in place. On every iteration the low multiplier bit decides whether the multiplicand is added into the accumulator. Then the chain formed by the carry, the accumulator and the multiplier register moves right by one position. The low half of the product therefore gradually replaces the multiplier bits.

A client raises `start` for one cycle while the block is idle. The block then raises `busy`. It runs exactly `W` iterations, one per clock, and pulses `done` for one cycle once the product is valid. The `product` output shows the accumulator joined to the multiplier register, with the accumulator as the upper half. It keeps its final value until the next accepted start.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is held and right after it, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` seen while `busy` is 0 loads the operands. One cycle later `busy` is 1, `product[W-1:0]` equals the multiplier `opb` and `product[2W-1:W]` equals 0.
- R3: In an iteration whose low multiplier-register bit (`product[0]`) is 1, the block adds `opa` into the upper half. The carry-out becomes the new most significant bit of the accumulator, and the whole `2W+1`-bit chain (carry, upper half, lower half) shifts right by one.
- R4: In an iteration whose `product[0]` is 0, the block adds nothing and only shifts the chain right by one. A zero enters the most significant bit.
- R5: `done` rises exactly `W` cycles after the cycle in which `busy` first reads 1.
- R6: When `done` is 1, `product` equals `opa * opb` as a full `2W`-bit unsigned product. This includes the largest operands, whose sums carry out of the accumulator.
- R7: `done` is high for exactly one cycle. In that cycle `busy` is already 0.
- R8: A `start` that arrives while `busy` is 1 is ignored. The running multiply keeps its operands and its iteration count.
- R9: While `busy` is 0 and no start is given, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| opa | input | W | Multiplicand |
| opb | input | W | Multiplier |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2W | Upper half accumulator, lower half multiplier register |

## Verification
The bound checker checks several rules on every cycle. It checks the loaded value one cycle after an accepted start. It counts busy cycles and requires exactly `W` of them before `done`. It compares the finished product against operands captured at the accepted start, so a start during a run that disturbed the result would show up there. It also checks that `done` is a single-cycle pulse and that the product holds while idle. The exact value of the add-and-shift after the first iteration, for both a set and a clear low bit, is checked only in the bench's scenarios. So are the reset values and the carry-heavy all-ones operands.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] addend_i,
    input  logic         en_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W:0] wide;

    always_comb begin
        if (en_i) begin
            wide = {1'b0, acc_i} + {1'b0, addend_i};
        end else begin
            wide = {1'b0, acc_i};
        end
        sum_o   = wide[W-1:0];
        carry_o = wide[W];
    end
endmodule

// File: rtl/mul_shifter.sv
module mul_shifter #(
    parameter int W = 8
) (
    input  logic         carry_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mplr_i,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] mplr_o
);
    generate
        if (W == 1) begin : g_single
            assign acc_o  = carry_i;
            assign mplr_o = acc_i;
        end else begin : g_multi
            assign acc_o  = {carry_i, acc_i[W-1:1]};
            assign mplr_o = {acc_i[0], mplr_i[W-1:1]};
        end
    endgenerate
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
    import mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        phase_e        ph;
        logic [W-1:0]  mcand;
        logic [W-1:0]  acc;
        logic [W-1:0]  mplr;
        logic [CW-1:0] iter;
        logic          fin;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] sum_w;
    logic         carry_w;
    logic [W-1:0] acc_sh_w;
    logic [W-1:0] mplr_sh_w;

    mul_adder #(.W(W)) u_add (
        .acc_i    (st_q.acc),
        .addend_i (st_q.mcand),
        .en_i     (st_q.mplr[0]),
        .sum_o    (sum_w),
        .carry_o  (carry_w)
    );

    mul_shifter #(.W(W)) u_shift (
        .carry_i (carry_w),
        .acc_i   (sum_w),
        .mplr_i  (st_q.mplr),
        .acc_o   (acc_sh_w),
        .mplr_o  (mplr_sh_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph    = PH_RUN;
                    st_d.mcand = opa;
                    st_d.mplr  = opb;
                    st_d.acc   = '0;
                    st_d.iter  = '0;
                end
            end
            default: begin
                st_d.acc  = acc_sh_w;
                st_d.mplr = mplr_sh_w;
                st_d.iter = st_q.iter + 1'b1;
                if (st_q.iter == LAST) begin
                    st_d.ph  = PH_IDLE;
                    st_d.fin = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, mcand: '0, acc: '0, mplr: '0, iter: '0, fin: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.ph == PH_RUN);
    assign done    = st_q.fin;
    assign product = {st_q.acc, st_q.mplr};
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   opa,
    input logic [W-1:0]   opb,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    logic [W-1:0] cap_a, cap_b;
    int unsigned  run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            run_cnt <= 0;
        end else if (start && !busy) begin
            cap_a   <= opa;
            cap_b   <= opb;
            run_cnt <= 0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && product == {{W{1'b0}}, $past(opb)}));

    a_r5_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == W));

    a_r6_value: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == PW'(cap_a) * PW'(cap_b)));

    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(product) && !busy));
endmodule

bind shift_add_mult shift_add_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opa     (opa),
    .opb     (opb),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/sim_shift_add_mult.sv
`timescale 1ns/1ps
module sim_shift_add_mult;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic          busy, done;
    logic [PW-1:0] product;

    int n_checks = 0;
    int n_fail   = 0;
    logic [PW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    shift_add_mult #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .product(product)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: pops the scoreboard when a result is announced (R6)
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected done", 64'(product), 64'(0));
            end else begin
                logic [PW-1:0] e;
                e = exp_q.pop_front();
                chk(product == e, "R6 product", 64'(product), 64'(e));
            end
        end
    end

    // Driver: one multiply, optional start injected mid-run (R8)
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit inject);
        logic [PW:0]   t;
        logic [PW-1:0] p1, fin;
        int n;
        fin = PW'(a) * PW'(b);
        exp_q.push_back(fin);
        @(negedge clk);
        start = 1'b1; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0; opa = ~a; opb = ~b;
        chk(busy == 1'b1, "R2 busy", 64'(busy), 64'(1));
        chk(product == {{W{1'b0}}, b}, "R2 load", 64'(product), 64'({{W{1'b0}}, b}));
        t = {1'b0, {W{1'b0}}, b};
        if (b[0]) t = t + {1'b0, a, {W{1'b0}}};
        p1 = t[PW:1];
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                if (b[0]) chk(product == p1, "R3 add-shift", 64'(product), 64'(p1));
                else      chk(product == p1, "R4 shift only", 64'(product), 64'(p1));
            end
            if (inject && n == 3) begin
                start = 1'b1; opa = 8'hFF; opb = 8'hFF;
            end else begin
                start = 1'b0;
            end
            if (done || n > W + 2) break;
        end
        chk(n == W, "R5 iteration count", 64'(n), 64'(W));
        chk(busy == 1'b0, "R7 busy low at done", 64'(busy), 64'(0));
        if (inject) chk(product == fin, "R8 start while busy ignored", 64'(product), 64'(fin));
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", 64'(done), 64'(0));
        repeat (3) @(negedge clk);
        chk(product == fin && !busy, "R9 product held", 64'(product), 64'(fin));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", 64'({busy, done}), 64'(0));
        chk(product == '0, "R1 reset product", 64'(product), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && product == '0, "R1 after reset", 64'(product), 64'(0));
        run_mul(8'd7,   8'd3,   1'b0);
        run_mul(8'd200, 8'd6,   1'b0);
        run_mul(8'hFF,  8'hFF,  1'b0);
        run_mul(8'd0,   8'd200, 1'b0);
        run_mul(8'd200, 8'd0,   1'b0);
        run_mul(8'd1,   8'hFF,  1'b0);
        run_mul(8'd128, 8'd2,   1'b0);
        run_mul(8'hAA,  8'h55,  1'b0);
        run_mul(8'd13,  8'd11,  1'b1);
        run_mul(8'h80,  8'h81,  1'b0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", 64'(exp_q.size()), 64'(0));
        finish_up();
    end
endmodule